// File: doc/BRIEF.md
# Edge-Offset Sample Filter

This block corrects a picture block by looking at the local edge shape around each sample. It compares every sample with two neighbours and adds one of five signed offsets. A two-bit direction setting picks the neighbours: a horizontal pair, a vertical pair, or one of the two diagonal pairs. The five offsets are programmed once per block. The result is clipped to the range of the selected bit depth, which may be 8, 10 or 12 bits.

A block is set up with a one-cycle `start` pulse. The pulse latches the bit depth, the direction, the offsets, the width (8 to 64) and the height. The caller then streams the padded block in raster order over a valid/ready handshake. The padded block has (height+2) rows of (width+2) samples, with one padding row above and below and one padding column on each side. Two internal row buffers keep the two rows already received, so each neighbour is available when the row below it arrives. The filtered interior samples leave in raster order, one per accepted transfer, through a second valid/ready handshake. A one-cycle `done` follows the last of them.

Top module: `sao_eo_filter`

## Requirements
- R1: With direction code 0, the neighbours of a sample are the samples to its left and to its right in the same row.
- R2: With direction code 1, the neighbours are the samples directly above and directly below.
- R3: With direction code 2, the neighbours are the sample above-left and the sample below-right.
- R4: With direction code 3, the neighbours are the sample above-right and the sample below-left.
- R5: The edge category is sign(c−a)+sign(c−b), computed with unsigned comparison. The category selects the offset slot as follows: −2 selects slot 1, −1 selects slot 2, 0 selects slot 0, +1 selects slot 3 and +2 selects slot 4. Slot k sits at bits [k*OFF_W +: OFF_W] of `cfg_offsets` as a two's-complement value.
- R6: The output is the current sample plus the selected offset, clipped to 0..2^depth−1. Depth code 0 means 8 bits, code 1 means 10 bits and code 2 means 12 bits.
- R7: Slot 0 is always applied, so a flat area moves by the programmed slot-0 value when that value is non-zero.
- R8: For a width W and height H, the block accepts (W+2)·(H+2) input samples and delivers exactly W·H outputs in raster order. Padding positions produce no output.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold, and `in_ready` stays low.
- R10: `done` is high for one cycle, in the cycle after the final output transfer, and is low at all other times.
- R11: After reset, `in_ready`, `out_valid` and `done` are low. `in_ready` rises only after a `start`.
- R12: Any width from 8 to 64 works, including 8, 48 and 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latches the configuration and begins a block (taken only while idle) |
| cfg_depth | input | 2 | Bit depth code: 0 for 8, 1 for 10, 2 for 12 |
| cfg_dir | input | 2 | Neighbour direction code 0..3 |
| cfg_width | input | CW | Interior width in samples |
| cfg_height | input | CW | Interior height in rows |
| cfg_offsets | input | 5*OFF_W | Five signed offsets, slot k at [k*OFF_W +: OFF_W] |
| in_valid | input | 1 | Input sample valid |
| in_data | input | PIX_W | Padded input sample, raster order |
| in_ready | output | 1 | Block accepts an input sample |
| out_valid | output | 1 | Filtered sample valid |
| out_data | output | PIX_W | Filtered sample |
| out_ready | input | 1 | Downstream accepts the output |
| done | output | 1 | One-cycle pulse after the final output |

## Verification
The embedded assertions check four things on every cycle: the output stays inside the clip range of the latched depth, the output holds steady while it is stalled, input is refused while a stalled output is pending, and `done` follows only a final-sample transfer. The assertions also check that the column counter stays within the padded row. Only the bench scenarios can show the arithmetic: that each direction picks the right neighbours, that the category maps to the right offset slot, that slot 0 is applied, and that the sample count and raster order are correct. The bench compares every output against a model of the padded frame under random back-pressure.

// File: rtl/sao_eo_pkg.sv
// Shared types and small helpers for the edge-offset filter.
// Assumes: the category is confined to -2..+2 by its construction.
package sao_eo_pkg;

    typedef enum logic [1:0] {
        DIR_HORZ      = 2'd0,
        DIR_VERT      = 2'd1,
        DIR_DIAG_DOWN = 2'd2,
        DIR_DIAG_UP   = 2'd3
    } eo_dir_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FEED  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    // Turn a greater/less pair into a signed unit step.
    function automatic logic signed [2:0] unit_sign(input logic gt, input logic lt);
        if (gt)      return 3'sd1;
        else if (lt) return -3'sd1;
        else         return 3'sd0;
    endfunction

    // Edge category to offset slot. The slot order is fixed by the decoding convention.
    function automatic logic [2:0] cat_to_slot(input logic signed [2:0] cat);
        case (cat)
            -3'sd2:  return 3'd1;
            -3'sd1:  return 3'd2;
            3'sd1:   return 3'd3;
            3'sd2:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/sao_eo_seq.sv
// Sequencer: walks the padded raster, tells the datapath when an interior
// sample can be produced, and flags the final input position.
// Assumes: width and height are at least 1, and width+1 and height+1 fit in CW bits.
module sao_eo_seq
    import sao_eo_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic          in_valid,
    input  logic          out_free,
    input  logic          last_drained,
    output logic          in_ready,
    output logic          accept,
    output logic          emit,
    output logic          last_in,
    output logic          idle,
    output logic [CW-1:0] col
);

    seq_state_e    state_q;
    logic [CW-1:0] col_q, row_q, w_q, h_q;

    assign idle     = (state_q == ST_IDLE);
    assign in_ready = (state_q == ST_FEED) && out_free;
    assign accept   = in_ready && in_valid;
    assign emit     = (row_q >= CW'(2)) && (col_q >= CW'(2));
    assign last_in  = (row_q == h_q + CW'(1)) && (col_q == w_q + CW'(1));
    assign col      = col_q;

    // Purpose: state machine and raster position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            col_q   <= '0;
            row_q   <= '0;
            w_q     <= '0;
            h_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        w_q     <= width;
                        h_q     <= height;
                        col_q   <= '0;
                        row_q   <= '0;
                        state_q <= ST_FEED;
                    end
                end
                ST_FEED: begin
                    if (accept) begin
                        if (col_q == w_q + CW'(1)) begin
                            col_q <= '0;
                            row_q <= row_q + CW'(1);
                        end else begin
                            col_q <= col_q + CW'(1);
                        end
                        if (last_in) state_q <= ST_DRAIN;
                    end
                end
                ST_DRAIN: begin
                    if (last_drained) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FEED) |-> (col_q <= w_q + CW'(1))); // R8

    AST_NO_TAKE_OUTSIDE_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FEED) |-> !accept); // R11

endmodule

// File: rtl/sao_eo_linebuf.sv
// Row storage and 3x3 neighbourhood windows. Two row buffers hold the two rows
// received before the current one. Each accepted sample pushes the column down
// through them, and a two-deep history per row forms the window.
// Assumes: the column index stays below LB_D.
module sao_eo_linebuf #(
    parameter int PIX_W = 12,
    parameter int LB_D  = 66,
    parameter int CW    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  shift_en,
    input  logic [CW-1:0]         col,
    input  logic [PIX_W-1:0]      pix_in,
    output logic [2:0][PIX_W-1:0] win_up,
    output logic [2:0][PIX_W-1:0] win_mid,
    output logic [2:0][PIX_W-1:0] win_dn
);

    localparam int ROWS = 3;

    logic [PIX_W-1:0] row_up  [LB_D];
    logic [PIX_W-1:0] row_mid [LB_D];

    // Index 0: row above, 1: middle row, 2: row arriving now.
    logic [ROWS-1:0][PIX_W-1:0] fresh;
    logic [ROWS-1:0][1:0][PIX_W-1:0] hist;

    assign fresh[0] = row_up[col];
    assign fresh[1] = row_mid[col];
    assign fresh[2] = pix_in;

    // Purpose: push the current column down one row on every accepted sample.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            row_up[col]  <= row_mid[col];
            row_mid[col] <= pix_in;
        end
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_hist
        // Purpose: keep the two previous columns of row g for the window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist[g] <= '0;
            end else if (shift_en) begin
                hist[g][0] <= hist[g][1];
                hist[g][1] <= fresh[g];
            end
        end
    end

    // Window index 2 is the newest column, 0 the oldest.
    assign win_up  = {fresh[0], hist[0][1], hist[0][0]};
    assign win_mid = {fresh[1], hist[1][1], hist[1][0]};
    assign win_dn  = {fresh[2], hist[2][1], hist[2][0]};

endmodule

// File: rtl/sao_eo_classify.sv
// Combinational core: picks the neighbour pair for the direction, forms the
// edge category from unsigned comparisons, selects the offset slot, adds the
// offset and clips to the depth range.
// Assumes: OFF_W < PIX_W+2 and max_val is 2^depth-1.
module sao_eo_classify
    import sao_eo_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int OFF_W = 10
) (
    input  logic [2:0][PIX_W-1:0] win_up,
    input  logic [2:0][PIX_W-1:0] win_mid,
    input  logic [2:0][PIX_W-1:0] win_dn,
    input  eo_dir_e               dir,
    input  logic [5*OFF_W-1:0]    offsets,
    input  logic [PIX_W-1:0]      max_val,
    output logic [PIX_W-1:0]      pix_out
);

    localparam int SW = PIX_W + 2;

    logic [PIX_W-1:0]     cur, nb_a, nb_b;
    logic signed [2:0]    cat;
    logic [2:0]           slot;
    logic [OFF_W-1:0]     off_raw;
    logic signed [SW-1:0] off_ext, sum, cap;

    // Purpose: neighbour selection per direction code.
    always_comb begin
        cur = win_mid[1];
        case (dir)
            DIR_HORZ:      begin nb_a = win_mid[0]; nb_b = win_mid[2]; end
            DIR_VERT:      begin nb_a = win_up[1];  nb_b = win_dn[1];  end
            DIR_DIAG_DOWN: begin nb_a = win_up[0];  nb_b = win_dn[2];  end
            default:       begin nb_a = win_up[2];  nb_b = win_dn[0];  end
        endcase
    end

    // Purpose: category, slot lookup, offset add and clip.
    always_comb begin
        cat     = unit_sign(cur > nb_a, cur < nb_a) + unit_sign(cur > nb_b, cur < nb_b);
        slot    = cat_to_slot(cat);
        off_raw = offsets[slot*OFF_W +: OFF_W];
        off_ext = {{(SW-OFF_W){off_raw[OFF_W-1]}}, off_raw};
        sum     = $signed({2'b00, cur}) + off_ext;
        cap     = $signed({2'b00, max_val});
        if (sum[SW-1])     pix_out = '0;
        else if (sum > cap) pix_out = max_val;
        else               pix_out = sum[PIX_W-1:0];
    end

endmodule

// File: rtl/sao_eo_filter.sv
// Top of the edge-offset filter. Latches the per-block configuration on start
// and runs the padded raster through the row buffers and the classifier. The
// interior results go to a single output register behind a valid/ready handshake.
// Assumes: the caller supplies one padding sample around every side of the block.
module sao_eo_filter
    import sao_eo_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int OFF_W = 10,
    parameter int MAX_W = 64,
    parameter int MAX_H = 64,
    localparam int MAX_D = (MAX_W > MAX_H) ? MAX_W : MAX_H,
    localparam int CW    = $clog2(MAX_D + 3),
    localparam int LB_D  = MAX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         cfg_depth,
    input  logic [1:0]         cfg_dir,
    input  logic [CW-1:0]      cfg_width,
    input  logic [CW-1:0]      cfg_height,
    input  logic [5*OFF_W-1:0] cfg_offsets,
    input  logic               in_valid,
    input  logic [PIX_W-1:0]   in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_data,
    input  logic               out_ready,
    output logic               done
);

    logic [1:0]          depth_q;
    eo_dir_e             dir_q;
    logic [5*OFF_W-1:0]  offs_q;
    logic [PIX_W-1:0]    max_val;
    logic                accept, emit, last_in, idle, out_last_q, out_fire;
    logic [CW-1:0]       col;
    logic [2:0][PIX_W-1:0] win_up, win_mid, win_dn;
    logic [PIX_W-1:0]    pix_res;

    assign out_fire = out_valid && out_ready;

    // Purpose: clip ceiling for the latched depth code.
    always_comb begin
        case (depth_q)
            2'd0:    max_val = PIX_W'(12'hFF);
            2'd1:    max_val = PIX_W'(12'h3FF);
            default: max_val = PIX_W'(12'hFFF);
        endcase
    end

    // Purpose: capture the per-block configuration when a block starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q <= '0;
            dir_q   <= DIR_HORZ;
            offs_q  <= '0;
        end else if (idle && start) begin
            depth_q <= cfg_depth;
            dir_q   <= eo_dir_e'(cfg_dir);
            offs_q  <= cfg_offsets;
        end
    end

    sao_eo_seq #(.CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .width        (cfg_width),
        .height       (cfg_height),
        .in_valid     (in_valid),
        .out_free     (!out_valid || out_ready),
        .last_drained (out_fire && out_last_q),
        .in_ready     (in_ready),
        .accept       (accept),
        .emit         (emit),
        .last_in      (last_in),
        .idle         (idle),
        .col          (col)
    );

    sao_eo_linebuf #(.PIX_W(PIX_W), .LB_D(LB_D), .CW(CW)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .col      (col),
        .pix_in   (in_data),
        .win_up   (win_up),
        .win_mid  (win_mid),
        .win_dn   (win_dn)
    );

    sao_eo_classify #(.PIX_W(PIX_W), .OFF_W(OFF_W)) u_class (
        .win_up  (win_up),
        .win_mid (win_mid),
        .win_dn  (win_dn),
        .dir     (dir_q),
        .offsets (offs_q),
        .max_val (max_val),
        .pix_out (pix_res)
    );

    // Purpose: output register; loads a result when an interior position completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_last_q <= 1'b0;
        end else if (accept && emit) begin
            out_valid  <= 1'b1;
            out_data   <= pix_res;
            out_last_q <= last_in;
        end else if (out_ready) begin
            out_valid  <= 1'b0;
            out_last_q <= 1'b0;
        end
    end

    // Purpose: end-of-block pulse after the final output transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= out_fire && out_last_q;
    end

    AST_OUT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data <= max_val)); // R6

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

    AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R9

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_fire && out_last_q)); // R10

endmodule

// File: tb/sao_eo_filter_tb.sv
module sao_eo_filter_tb;

    localparam int PIX_W = 12;
    localparam int OFF_W = 10;
    localparam int CW    = 7;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         cfg_depth = '0;
    logic [1:0]         cfg_dir = '0;
    logic [CW-1:0]      cfg_width = '0;
    logic [CW-1:0]      cfg_height = '0;
    logic [5*OFF_W-1:0] cfg_offsets = '0;
    logic               in_valid = 1'b0;
    logic [PIX_W-1:0]   in_data = '0;
    logic               in_ready;
    logic               out_valid;
    logic [PIX_W-1:0]   out_data;
    logic               out_ready = 1'b0;
    logic               done;

    int checks = 0;
    int errors = 0;

    int frame [0:65][0:65];
    int offs  [0:4];
    int cur_dir, cur_bits;

    always #2 clk = ~clk;

    sao_eo_filter u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_depth(cfg_depth), .cfg_dir(cfg_dir),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_offsets(cfg_offsets),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        if (v > 0) return 1;
        if (v < 0) return -1;
        return 0;
    endfunction

    // Model of one interior sample at padded position (r, c).
    function automatic int model(input int r, input int c);
        int cv, a, b, cat, k, v, mx;
        cv = frame[r][c];
        case (cur_dir)
            0:       begin a = frame[r][c-1];   b = frame[r][c+1];   end
            1:       begin a = frame[r-1][c];   b = frame[r+1][c];   end
            2:       begin a = frame[r-1][c-1]; b = frame[r+1][c+1]; end
            default: begin a = frame[r-1][c+1]; b = frame[r+1][c-1]; end
        endcase
        cat = sgn(cv - a) + sgn(cv - b);
        case (cat)
            -2: k = 1;
            -1: k = 2;
            1:  k = 3;
            2:  k = 4;
            default: k = 0;
        endcase
        v  = cv + offs[k];
        mx = (1 << cur_bits) - 1;
        if (v < 0) v = 0;
        if (v > mx) v = mx;
        return v;
    endfunction

    // mode 0: random, 1: flat 100, 2: extremes of the range
    task automatic run_case(input int w, input int h, input int dcode, input int dir,
                            input int mode, input string tag);
        int mx;
        cur_dir  = dir;
        cur_bits = (dcode == 0) ? 8 : (dcode == 1) ? 10 : 12;
        mx = (1 << cur_bits) - 1;
        for (int r = 0; r < h + 2; r++)
            for (int c = 0; c < w + 2; c++) begin
                case (mode)
                    0: frame[r][c] = int'($urandom % (mx + 1));
                    1: frame[r][c] = 100;
                    default: begin
                        case ($urandom % 4)
                            0: frame[r][c] = 0;
                            1: frame[r][c] = 1;
                            2: frame[r][c] = mx - 1;
                            default: frame[r][c] = mx;
                        endcase
                    end
                endcase
            end
        @(negedge clk);
        cfg_depth  = 2'(dcode);
        cfg_dir    = 2'(dir);
        cfg_width  = CW'(w);
        cfg_height = CW'(h);
        for (int k = 0; k < 5; k++) cfg_offsets[k*OFF_W +: OFF_W] = OFF_W'(offs[k]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin : driver
                for (int r = 0; r < h + 2; r++)
                    for (int c = 0; c < w + 2; c++) begin
                        @(negedge clk);
                        in_valid = 1'b1;
                        in_data  = PIX_W'(frame[r][c]);
                        #1;
                        while (!in_ready) begin
                            @(negedge clk);
                            #1;
                        end
                    end
                @(negedge clk);
                in_valid = 1'b0;
            end
            begin : consumer
                int  n;
                bit  stalled;
                logic [PIX_W-1:0] held;
                n = 0;
                stalled = 1'b0;
                held = '0;
                while (n < w * h) begin
                    @(negedge clk);
                    out_ready = (($urandom % 10) < 7);
                    #1;
                    if (stalled)
                        chk(out_valid && out_data == held, {"R9 hold ", tag},
                            int'(out_data), int'(held));
                    if (out_valid && !out_ready)
                        chk(!in_ready, {"R9 ready low ", tag}, int'(in_ready), 0);
                    chk(!done, {"R10 early done ", tag}, int'(done), 0);
                    stalled = out_valid && !out_ready;
                    held    = out_data;
                    if (out_valid && out_ready) begin
                        chk(int'(out_data) == model(1 + n / w, 1 + n % w), tag,
                            int'(out_data), model(1 + n / w, 1 + n % w));
                        n++;
                    end
                end
                @(negedge clk);
                out_ready = 1'b1;
                #1;
                chk(done == 1'b1, {"R10 done pulse ", tag}, int'(done), 1);
                chk(out_valid == 1'b0, {"R8 no extra output ", tag}, int'(out_valid), 0);
                @(negedge clk);
                #1;
                chk(done == 1'b0, {"R10 single pulse ", tag}, int'(done), 0);
            end
        join
    endtask

    task automatic rand_offs(input int lim);
        for (int k = 0; k < 5; k++) offs[k] = int'($urandom % (2 * lim + 1)) - lim;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R11: reset state
        chk(!in_ready && !out_valid && !done, "R11 reset state",
            int'({in_ready, out_valid, done}), 0);

        rand_offs(7);
        run_case(8, 4, 0, 0, 0, "R1 R5 horizontal d8");
        rand_offs(30);
        run_case(16, 3, 1, 1, 0, "R2 R5 vertical d10");
        rand_offs(100);
        run_case(32, 2, 2, 2, 0, "R3 R5 diag-down d12");
        rand_offs(7);
        run_case(48, 2, 0, 3, 2, "R4 R12 diag-up w48");
        rand_offs(20);
        run_case(64, 2, 1, 2, 0, "R12 R8 w64");
        offs = '{5, 0, 0, 0, 0};
        run_case(8, 2, 0, 1, 1, "R7 slot0 flat");
        offs = '{-3, 200, 150, -150, -200};
        run_case(8, 3, 0, 0, 2, "R6 clip d8");
        offs = '{0, 400, 300, -300, -400};
        run_case(16, 2, 2, 3, 2, "R6 clip d12");
        offs = '{0, 9, 4, -4, -9};
        run_case(8, 5, 0, 2, 0, "R5 slot order");

        @(negedge clk);
        #1;
        chk(!in_ready, "R11 idle after block", int'(in_ready), 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule